// File: doc/BRIEF.md
# Float-to-integer truncating converter

The block converts an IEEE-754 single-precision number into a signed 32-bit two's-complement integer. The fraction is always dropped toward zero, and no rounding setting is involved. The operand arrives as a 128-bit vector. Only its low 32 bits are treated as the float, and the upper bits play no part. One operation is accepted per cycle, marked by `in_valid`. The result, together with that operation's status, appears on registered outputs one cycle later.

Two numeric conditions are reported: invalid operation and precision (inexact). A NaN, an infinity, or a value outside the signed 32-bit range gives the sentinel 0x80000000 and raises invalid. Each condition has a mask bit, sampled together with the operand. When a condition occurs and its mask is 0, the block pulses an exception request. Sticky copies of both flags gather status across operations until they are cleared by a synchronous pulse.

Top module: `f2i_trunc_cvt`

## Requirements
- R1: Only bits [31:0] of `in_vec` affect the conversion. Bits [127:32] have no effect on the result or on any flag.
- R2: A finite value whose truncation lies within the signed 32-bit range gives that truncated integer in two's complement. For example, -2.75 gives 0xFFFFFFFE and 2.75 gives 2.
- R3: Zeros, denormals and values of magnitude below 1.0 give 0. Precision is set for all of them except an exact zero of either sign.
- R4: A finite value whose truncation is at or above +2^31, or below -2^31, gives 0x80000000 with invalid set and precision clear.
- R5: A NaN (quiet or signalling) or an infinity of either sign gives 0x80000000 with invalid set and precision clear.
- R6: An input exactly equal to -2^31 (0xCF000000) gives 0x80000000 with both flags clear.
- R7: Precision is set exactly when a valid conversion discards nonzero fraction bits. It is never set together with invalid.
- R8: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. The result and status flags are valid in that cycle.
- R9: `sticky_inv` and `sticky_prec` OR in each new operation's status at the edge where the result is registered. A `clr_sticky` pulse zeroes them at the next edge. A status registered at that same edge is still kept.
- R10: `exc_req` is high only together with `out_valid`. It is high when invalid is set and `mask_inv` was 0, or when precision is set and `mask_prec` was 0. Both masks are taken in the `in_valid` cycle. With both masks at 1, no request is raised.
- R11: While reset is held and after it is released, `out_valid`, `out_result`, both status flags, both sticky flags and `exc_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_vec | input | 128 | Vector operand; low 32 bits hold the float |
| mask_inv | input | 1 | 1 masks the invalid-operation request |
| mask_prec | input | 1 | 1 masks the precision request |
| clr_sticky | input | 1 | Synchronous clear of the sticky flags |
| out_valid | output | 1 | Result registered this cycle |
| out_result | output | 32 | Signed integer result |
| out_inv | output | 1 | Invalid status of the registered operation |
| out_prec | output | 1 | Precision status of the registered operation |
| sticky_inv | output | 1 | Accumulated invalid status |
| sticky_prec | output | 1 | Accumulated precision status |
| exc_req | output | 1 | Unmasked-condition exception request |

## Verification
The hardest case to reach from the ports is the boundary at -2^31. There the exact value must pass with no flags, while the next representable float below it must be rejected. Both patterns are therefore driven directly as 0xCF000000 and 0xCF000001, next to 0x4F000000 and the largest in-range float 0x4EFFFFFF. Driving a clear pulse in the same cycle as an invalid operand is also awkward. The bench first sets the precision sticky flag with an inexact input, then issues that combined cycle, and checks that precision is dropped while invalid is kept.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;

  typedef struct packed {
    logic inv;
    logic prec;
  } cvt_status_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FP_W = EXP_W + MAN_W + 1
) (
  input  logic [FP_W-1:0]  fp_bits,
  output logic             sign,
  output logic [EXP_W-1:0] expo,
  output logic [MAN_W-1:0] mant,
  output logic             is_special,
  output logic             is_zero_exp
);
  assign sign        = fp_bits[FP_W-1];
  assign expo        = fp_bits[MAN_W +: EXP_W];
  assign mant        = fp_bits[MAN_W-1:0];
  assign is_special  = &expo;
  assign is_zero_exp = ~|expo;
endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc
  import f2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic             sign,
  input  logic [EXP_W-1:0] expo,
  input  logic [MAN_W-1:0] mant,
  input  logic             is_special,
  input  logic             is_zero_exp,
  output logic [INT_W-1:0] result,
  output cvt_status_t      status
);
  localparam int WIDE_W = INT_W + MAN_W;
  localparam logic [EXP_W-1:0] BIAS_E = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0] LIM_E  = BIAS_E + EXP_W'(INT_W - 1);
  localparam logic [INT_W-1:0] INDEF  = {1'b1, {(INT_W-1){1'b0}}};

  logic [EXP_W-1:0]  sh_amt;
  logic [WIDE_W-1:0] wide;
  logic [INT_W-1:0]  mag;
  logic              below_one;
  logic              too_big;
  logic              min_neg;

  assign below_one = expo < BIAS_E;
  assign too_big   = expo >= LIM_E;
  assign min_neg   = sign && (expo == LIM_E) && (mant == '0);
  assign sh_amt    = expo - BIAS_E;
  assign wide      = {{(INT_W-1){1'b0}}, 1'b1, mant} << sh_amt;
  assign mag       = wide[MAN_W +: INT_W];

  always_comb begin
    result = '0;
    status = '0;
    if (is_special) begin
      result     = INDEF;
      status.inv = 1'b1;
    end else if (is_zero_exp) begin
      status.prec = |mant;
    end else if (below_one) begin
      status.prec = 1'b1;
    end else if (too_big) begin
      result     = INDEF;
      status.inv = !min_neg;
    end else begin
      status.prec = |wide[MAN_W-1:0];
      result      = sign ? (~mag + 1'b1) : mag;
    end
  end
endmodule

// File: rtl/f2i_trunc_cvt.sv
module f2i_trunc_cvt
  import f2i_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int EXP_W = SP_EXP_W,
  parameter int MAN_W = SP_MAN_W,
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_vec,
  input  logic             mask_inv,
  input  logic             mask_prec,
  input  logic             clr_sticky,
  output logic             out_valid,
  output logic [INT_W-1:0] out_result,
  output logic             out_inv,
  output logic             out_prec,
  output logic             sticky_inv,
  output logic             sticky_prec,
  output logic             exc_req
);
  localparam int FP_W = EXP_W + MAN_W + 1;

  logic             f_sign;
  logic [EXP_W-1:0] f_expo;
  logic [MAN_W-1:0] f_mant;
  logic             f_special;
  logic             f_zero_exp;
  logic [INT_W-1:0] c_result;
  cvt_status_t      c_status;
  cvt_status_t      new_st;

  f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .fp_bits    (in_vec[FP_W-1:0]),
    .sign       (f_sign),
    .expo       (f_expo),
    .mant       (f_mant),
    .is_special (f_special),
    .is_zero_exp(f_zero_exp)
  );

  f2i_trunc #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_trunc (
    .sign       (f_sign),
    .expo       (f_expo),
    .mant       (f_mant),
    .is_special (f_special),
    .is_zero_exp(f_zero_exp),
    .result     (c_result),
    .status     (c_status)
  );

  assign new_st = in_valid ? c_status : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inv     <= 1'b0;
      out_prec    <= 1'b0;
      exc_req     <= 1'b0;
      sticky_inv  <= 1'b0;
      sticky_prec <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      if (in_valid) begin
        out_result <= c_result;
        out_inv    <= c_status.inv;
        out_prec   <= c_status.prec;
      end
      exc_req     <= (new_st.inv && !mask_inv) || (new_st.prec && !mask_prec);
      sticky_inv  <= (sticky_inv  && !clr_sticky) || new_st.inv;
      sticky_prec <= (sticky_prec && !clr_sticky) || new_st.prec;
    end
  end

  // R7: status flags are mutually exclusive
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_inv && out_prec));

  // R4 / R5: invalid always carries the sentinel
  a_r4_indef_on_invalid: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_inv) |-> (out_result == {1'b1, {(INT_W-1){1'b0}}}));

  // R8: one-cycle latency, single pulse per operand
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9: a reported status is reflected in the sticky copy
  a_r9_sticky_inv: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_inv) |-> sticky_inv);
  a_r9_sticky_prec: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_prec) |-> sticky_prec);

  // R10: request only alongside a result carrying some status
  a_r10_req_with_status: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (out_valid && (out_inv || out_prec)));
endmodule

// File: tb/sim_f2i_trunc_cvt.sv
module sim_f2i_trunc_cvt;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_vec = '0;
  logic         mask_inv = 1'b1;
  logic         mask_prec = 1'b1;
  logic         clr_sticky = 1'b0;
  logic         out_valid;
  logic [31:0]  out_result;
  logic         out_inv;
  logic         out_prec;
  logic         sticky_inv;
  logic         sticky_prec;
  logic         exc_req;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] INDEF = 32'h8000_0000;

  always #10 clk = ~clk;

  f2i_trunc_cvt u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .mask_inv(mask_inv), .mask_prec(mask_prec), .clr_sticky(clr_sticky),
    .out_valid(out_valid), .out_result(out_result), .out_inv(out_inv),
    .out_prec(out_prec), .sticky_inv(sticky_inv), .sticky_prec(sticky_prec),
    .exc_req(exc_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One operand, check its result, status and request, then the idle cycle.
  task automatic conv(input string tag, input logic [127:0] v, input logic mi, input logic mp,
                      input logic [31:0] er, input logic ei, input logic ep, input logic ee);
    @(negedge clk);
    in_valid = 1'b1; in_vec = v; mask_inv = mi; mask_prec = mp;
    @(negedge clk);
    in_valid = 1'b0; in_vec = {128{1'b1}}; mask_inv = ~mi; mask_prec = ~mp;
    chk({tag, " R8 out_valid"}, {31'b0, out_valid}, 32'd1);
    chk({tag, " result"}, out_result, er);
    chk({tag, " inv"}, {31'b0, out_inv}, {31'b0, ei});
    chk({tag, " prec"}, {31'b0, out_prec}, {31'b0, ep});
    chk({tag, " R10 exc_req"}, {31'b0, exc_req}, {31'b0, ee});
    @(negedge clk);
    chk({tag, " R8 idle"}, {31'b0, out_valid}, 32'd0);
    chk({tag, " R10 idle req"}, {31'b0, exc_req}, 32'd0);
  endtask

  task automatic chk_sticky(input string tag, input logic ei, input logic ep);
    chk({tag, " R9 sticky_inv"}, {31'b0, sticky_inv}, {31'b0, ei});
    chk({tag, " R9 sticky_prec"}, {31'b0, sticky_prec}, {31'b0, ep});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11 valid in reset", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 valid", {31'b0, out_valid}, 32'd0);
    chk("R11 result", out_result, 32'd0);
    chk("R11 flags", {30'b0, out_inv, out_prec}, 32'd0);
    chk("R11 sticky", {30'b0, sticky_inv, sticky_prec}, 32'd0);
    chk("R11 exc", {31'b0, exc_req}, 32'd0);
  endtask

  task automatic t_truncate();
    conv("R2 1.0", 128'h3F80_0000, 1, 1, 32'd1, 0, 0, 0);
    conv("R2 -1.5", 128'hBFC0_0000, 1, 1, 32'hFFFF_FFFF, 0, 1, 0);
    conv("R2 2.75", 128'h4030_0000, 1, 1, 32'd2, 0, 1, 0);
    conv("R2 -2.75", 128'hC030_0000, 1, 1, 32'hFFFF_FFFE, 0, 1, 0);
    conv("R7 1.9999999", 128'h3FFF_FFFF, 1, 1, 32'd1, 0, 1, 0);
    conv("R7 8388609", 128'h4B00_0001, 1, 1, 32'd8388609, 0, 0, 0);
    conv("R2 max in range", 128'h4EFF_FFFF, 1, 1, 32'h7FFF_FF80, 0, 0, 0);
  endtask

  task automatic t_small();
    conv("R3 +0", 128'h0000_0000, 1, 1, 32'd0, 0, 0, 0);
    conv("R3 -0", 128'h8000_0000, 1, 1, 32'd0, 0, 0, 0);
    conv("R3 denormal", 128'h0000_0001, 1, 1, 32'd0, 0, 1, 0);
    conv("R3 0.5", 128'h3F00_0000, 1, 1, 32'd0, 0, 1, 0);
    conv("R3 -0.5", 128'hBF00_0000, 1, 1, 32'd0, 0, 1, 0);
  endtask

  task automatic t_range();
    conv("R4 2^31", 128'h4F00_0000, 1, 1, INDEF, 1, 0, 0);
    conv("R6 -2^31", 128'hCF00_0000, 1, 1, INDEF, 0, 0, 0);
    conv("R4 below -2^31", 128'hCF00_0001, 1, 1, INDEF, 1, 0, 0);
    conv("R4 1e38", 128'h7E96_7699, 1, 1, INDEF, 1, 0, 0);
  endtask

  task automatic t_special();
    conv("R5 +inf", 128'h7F80_0000, 1, 1, INDEF, 1, 0, 0);
    conv("R5 -inf", 128'hFF80_0000, 1, 1, INDEF, 1, 0, 0);
    conv("R5 qNaN", 128'h7FC0_0000, 1, 1, INDEF, 1, 0, 0);
    conv("R5 sNaN", 128'h7F80_0001, 1, 1, INDEF, 1, 0, 0);
  endtask

  task automatic t_upper();
    conv("R1 upper junk", {96'hDEAD_BEEF_7F80_0000_CAFE_F00D, 32'h4030_0000}, 1, 1, 32'd2, 0, 1, 0);
    conv("R1 upper ones", {{96{1'b1}}, 32'h3F80_0000}, 1, 1, 32'd1, 0, 0, 0);
  endtask

  task automatic t_except();
    conv("R10 prec unmasked", 128'h4030_0000, 1, 0, 32'd2, 0, 1, 1);
    conv("R10 prec masked", 128'h4030_0000, 0, 1, 32'd2, 0, 1, 0);
    conv("R10 inv unmasked", 128'h7F80_0000, 0, 1, INDEF, 1, 0, 1);
    conv("R10 inv masked", 128'h7F80_0000, 1, 0, INDEF, 1, 0, 0);
    conv("R10 exact no req", 128'h3F80_0000, 0, 0, 32'd1, 0, 0, 0);
    conv("R10 -2^31 no req", 128'hCF00_0000, 0, 0, INDEF, 0, 0, 0);
  endtask

  task automatic t_sticky();
    @(negedge clk); clr_sticky = 1'b1;
    @(negedge clk); clr_sticky = 1'b0;
    chk_sticky("clear", 0, 0);
    conv("R9 exact", 128'h3F80_0000, 1, 1, 32'd1, 0, 0, 0);
    chk_sticky("after exact", 0, 0);
    conv("R9 inexact", 128'h4030_0000, 1, 1, 32'd2, 0, 1, 0);
    chk_sticky("after inexact", 0, 1);
    conv("R9 exact again", 128'h3F80_0000, 1, 1, 32'd1, 0, 0, 0);
    chk_sticky("held", 0, 1);
    // clear together with an invalid operand
    @(negedge clk);
    in_valid = 1'b1; in_vec = 128'h7F80_0000; clr_sticky = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clr_sticky = 1'b0;
    chk("R9 same-cycle inv", {31'b0, out_inv}, 32'd1);
    chk_sticky("clear with new status", 1, 0);
    @(negedge clk); clr_sticky = 1'b1;
    @(negedge clk); clr_sticky = 1'b0;
    chk_sticky("final clear", 0, 0);
  endtask

  initial begin
    t_reset();
    t_truncate();
    t_small();
    t_range();
    t_special();
    t_upper();
    t_except();
    t_sticky();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule